// File: doc/BRIEF.md
# Interrupt-Raising Mailbox Bank

This block holds a bank of mailboxes. Each mailbox is a 64-bit word, and 128 of them fill 1 KB when counted in bytes. A bus master raises an interrupt just by writing to a mailbox, so the bank can act as the target of message-signalled interrupts. Each write is first merged into the stored word by the input function chosen for that mailbox. The merged word is then tested against the mailbox's trigger rule. When the rule holds, the interrupt line for that mailbox pulses.

Each mailbox has three more registers: a 4-bit control register, a 64-bit compare value and a 64-bit bit-select mask. The port is a simple one: single-cycle writes, and reads that return data one cycle later. The address is a word address. Its upper two bits pick the register space and its lower bits pick the mailbox. The 128 interrupt lines go to a routing stage that is not part of this block.

Top module: `mbx_mailbox_irq`

## Requirements
- R1: After reset (`rst_ni` low), every mailbox word, control register, compare value and mask reads as zero. `irq_o` is all zeros and `rdata_o` is zero.
- R2: `addr_i` is {space[1:0], index}. Space 0 is the mailbox word, 1 is the control register, 2 is the compare value and 3 is the mask. A read with `rd_i` high returns the addressed register on `rdata_o` in the next cycle. The control register is zero-extended. A read changes no state and raises no interrupt.
- R3: Control bits [1:0] select the input function. Value 0 (and the spare value 3) means replace: the word becomes the written data.
- R4: Input function 1 ORs the written data into the word.
- R5: Input function 2 adds the written data to the word, modulo 2^64.
- R6: Control bits [3:2] select the trigger. Value 0 fires on every write to the mailbox word.
- R7: Trigger 1 fires only when the merged word equals that mailbox's compare value.
- R8: Trigger 2 fires only when the merged word has at least one bit set that is also set in that mailbox's mask.
- R9: Trigger 3 never fires.
- R10: A firing write sets only that mailbox's bit of `irq_o`. The bit is high for exactly the one cycle after the write's clock edge.
- R11: A write of zero under a replace function clears the word and fires nothing, unless the trigger is 0.
- R12: Writes to the control, compare or mask spaces never raise an interrupt.
- R13: When a read and a write hit the same register in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | IDX_W+2 | {space, mailbox index} |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, one cycle after `rd_i` |
| irq_o | output | N_MBOX | One interrupt pulse line per mailbox |

## Verification
The bench builds the bank with `N_MBOX` = 8 and keeps `DATA_W` at 64. The small bank makes it practical to sweep every mailbox through all 16 combinations of input function and trigger. Each combination gets a four-write sequence that includes a zero write, an add that wraps past 2^64, a hit on the compare value and a hit and a miss on the mask. With only eight interrupt lines, each write is checked against the whole `irq_o` vector. That catches pulses raised on the wrong mailbox, pulses that last too long and pulses raised by configuration writes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {SP_DATA = 2'd0, SP_CFG = 2'd1, SP_MATCH = 2'd2, SP_MASK = 2'd3} space_e;
  typedef enum logic [1:0] {FN_REPL = 2'd0, FN_OR = 2'd1, FN_ADD = 2'd2, FN_REPL_ALT = 2'd3} func_e;
  typedef enum logic [1:0] {TR_ANY = 2'd0, TR_EQ = 2'd1, TR_MASK = 2'd2, TR_NEVER = 2'd3} trig_e;

  typedef struct packed {
    trig_e trig;
    func_e func;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/mbx_merge.sv
module mbx_merge
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  func_e              func_i,
  input  logic [DATA_W-1:0]  old_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  new_o,
  output logic               zero_repl_o
);
  logic is_repl;
  assign is_repl = (func_i == FN_REPL) || (func_i == FN_REPL_ALT);

  always_comb begin
    unique case (func_i)
      FN_OR:   new_o = old_i | wdata_i;
      FN_ADD:  new_o = old_i + wdata_i;
      default: new_o = wdata_i;
    endcase
  end

  assign zero_repl_o = is_repl && (wdata_i == '0);
endmodule

// File: rtl/mbx_trigger.sv
module mbx_trigger
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  trig_e              trig_i,
  input  logic [DATA_W-1:0]  new_i,
  input  logic [DATA_W-1:0]  match_i,
  input  logic [DATA_W-1:0]  mask_i,
  input  logic               zero_repl_i,
  output logic               fire_o
);
  logic cond;

  always_comb begin
    unique case (trig_i)
      TR_ANY:  cond = 1'b1;
      TR_EQ:   cond = (new_i == match_i);
      TR_MASK: cond = |(new_i & mask_i);
      default: cond = 1'b0;
    endcase
  end

  // zero replace clears quietly unless every write fires
  assign fire_o = cond && !(zero_repl_i && (trig_i != TR_ANY));
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               wr_data_i,
  input  logic               wr_cfg_i,
  input  logic               wr_match_i,
  input  logic               wr_mask_i,
  input  logic [DATA_W-1:0]  merged_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               fire_i,
  output logic [DATA_W-1:0]  data_o,
  output cfg_t               cfg_o,
  output logic [DATA_W-1:0]  match_o,
  output logic [DATA_W-1:0]  mask_o,
  output logic               irq_o
);
  logic [DATA_W-1:0] data_q, match_q, mask_q;
  cfg_t              cfg_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      match_q <= '0;
      mask_q  <= '0;
      cfg_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= sel_i && wr_data_i && fire_i;
      if (sel_i && wr_data_i)  data_q  <= merged_i;
      if (sel_i && wr_cfg_i)   cfg_q   <= cfg_t'(wdata_i[CFG_W-1:0]);
      if (sel_i && wr_match_i) match_q <= wdata_i;
      if (sel_i && wr_mask_i)  mask_q  <= wdata_i;
    end
  end

  assign data_o  = data_q;
  assign cfg_o   = cfg_q;
  assign match_o = match_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;

  a_r2_word_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_data_i) |=> $stable(data_q));
  a_r10_irq_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(sel_i && wr_data_i));
endmodule

// File: rtl/mbx_mailbox_irq.sv
module mbx_mailbox_irq
  import mbx_pkg::*;
#(
  parameter int unsigned N_MBOX = 128,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned IDX_W  = $clog2(N_MBOX),
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [N_MBOX-1:0]   irq_o
);
  space_e            space;
  logic [IDX_W-1:0]  idx;
  logic              in_range;

  assign space    = space_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx      = addr_i[IDX_W-1:0];
  assign in_range = 32'(idx) < N_MBOX;

  logic [DATA_W-1:0] data_a  [N_MBOX];
  logic [DATA_W-1:0] match_a [N_MBOX];
  logic [DATA_W-1:0] mask_a  [N_MBOX];
  cfg_t              cfg_a   [N_MBOX];

  logic wr_data, wr_cfg, wr_match, wr_mask;
  assign wr_data  = wr_i && in_range && (space == SP_DATA);
  assign wr_cfg   = wr_i && in_range && (space == SP_CFG);
  assign wr_match = wr_i && in_range && (space == SP_MATCH);
  assign wr_mask  = wr_i && in_range && (space == SP_MASK);

  logic [DATA_W-1:0] cur_data, cur_match, cur_mask;
  cfg_t              cur_cfg;

  always_comb begin
    cur_data  = '0;
    cur_match = '0;
    cur_mask  = '0;
    cur_cfg   = '0;
    if (in_range) begin
      cur_data  = data_a[idx];
      cur_match = match_a[idx];
      cur_mask  = mask_a[idx];
      cur_cfg   = cfg_a[idx];
    end
  end

  // one shared merge/trigger datapath: at most one write per cycle
  logic [DATA_W-1:0] merged;
  logic              zero_repl, fire;

  mbx_merge #(.DATA_W(DATA_W)) u_merge (
    .func_i      (cur_cfg.func),
    .old_i       (cur_data),
    .wdata_i     (wdata_i),
    .new_o       (merged),
    .zero_repl_o (zero_repl)
  );

  mbx_trigger #(.DATA_W(DATA_W)) u_trig (
    .trig_i      (cur_cfg.trig),
    .new_i       (merged),
    .match_i     (cur_match),
    .mask_i      (cur_mask),
    .zero_repl_i (zero_repl),
    .fire_o      (fire)
  );

  for (genvar g = 0; g < N_MBOX; g++) begin : g_slot
    logic sel;
    assign sel = (32'(idx) == g);
    mbx_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (sel),
      .wr_data_i  (wr_data),
      .wr_cfg_i   (wr_cfg),
      .wr_match_i (wr_match),
      .wr_mask_i  (wr_mask),
      .merged_i   (merged),
      .wdata_i    (wdata_i),
      .fire_i     (fire),
      .data_o     (data_a[g]),
      .cfg_o      (cfg_a[g]),
      .match_o    (match_a[g]),
      .mask_o     (mask_a[g]),
      .irq_o      (irq_o[g])
    );
  end

  logic [DATA_W-1:0] rd_mux, rdata_q;
  always_comb begin
    unique case (space)
      SP_DATA:  rd_mux = cur_data;
      SP_CFG:   rd_mux = {{(DATA_W-CFG_W){1'b0}}, cur_cfg};
      SP_MATCH: rd_mux = cur_match;
      default:  rd_mux = cur_mask;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  a_r10_single_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  a_r6_any_write_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && cur_cfg.trig == TR_ANY) |=> (|irq_o));
  a_r11_zero_replace_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && (cur_cfg.func == FN_REPL || cur_cfg.func == FN_REPL_ALT)
     && wdata_i == '0 && cur_cfg.trig != TR_ANY) |=> (irq_o == '0));
  a_r12_cfg_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && space != SP_DATA) |=> (irq_o == '0));
  a_r9_never_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && cur_cfg.trig == TR_NEVER) |=> (irq_o == '0));
endmodule

// File: tb/tb_mbx_mailbox_irq.sv
module tb_mbx_mailbox_irq;
  localparam int N = 8;
  localparam int DW = 64;
  localparam int AW = $clog2(N) + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [N-1:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbx_mailbox_irq #(.N_MBOX(N), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sp, input int i, input logic [DW-1:0] d,
                    input logic [N-1:0] exp_irq, input string req);
    @(negedge clk);
    wr_i = 1'b1; addr_i = {sp, 3'(i)}; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
    chk(irq_o === exp_irq, req, DW'(irq_o), DW'(exp_irq));
  endtask

  task automatic rd(input logic [1:0] sp, input int i, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    rd_i = 1'b1; addr_i = {sp, 3'(i)};
    @(negedge clk);
    rd_i = 1'b0;
    chk(rdata_o === exp, req, rdata_o, exp);
    chk(irq_o === '0, "R2", DW'(irq_o), '0);
  endtask

  function automatic logic [DW-1:0] pred(input logic [DW-1:0] old, input logic [DW-1:0] w, input int f);
    case (f)
      1: return old | w;
      2: return old + w;
      default: return w;
    endcase
  endfunction

  function automatic logic fires(input int t, input int f, input logic [DW-1:0] w,
                                 input logic [DW-1:0] nv, input logic [DW-1:0] m, input logic [DW-1:0] k);
    if ((f == 0 || f == 3) && w == '0 && t != 0) return 1'b0;
    case (t)
      0: return 1'b1;
      1: return nv == m;
      2: return |(nv & k);
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string rq_t [4];
    string rq_f [4];
    rq_t = '{"R6", "R7", "R8", "R9"};
    rq_f = '{"R3", "R4", "R5", "R3"};
    repeat (3) @(negedge clk);
    chk(irq_o === '0, "R1", DW'(irq_o), '0);
    chk(rdata_o === '0, "R1", rdata_o, '0);
    rst_ni = 1'b1;
    for (int i = 0; i < N; i++)
      for (int s = 0; s < 4; s++) rd(2'(s), i, '0, "R1");

    for (int i = 0; i < N; i++) begin
      for (int f = 0; f < 4; f++) begin
        for (int t = 0; t < 4; t++) begin
          logic [DW-1:0] w [4];
          logic [DW-1:0] v, m, k, nv;
          wr(2'd1, i, 64'hC, '0, "R12");
          wr(2'd0, i, '0, '0, "R11");
          rd(2'd0, i, '0, "R11");
          w[0] = 64'h10 + 64'(i);
          w[1] = 64'h0000_0001_0000_0300 + 64'(f * 4 + t);
          w[2] = '0;
          w[3] = 64'hFFFF_FFFF_FFFF_FFF0;
          v = '0;
          m = pred(pred('0, w[0], f), w[1], f);
          k = 64'h8000_0000_0000_0200;
          wr(2'd1, i, 64'(t * 4 + f), '0, "R12");
          wr(2'd2, i, m, '0, "R12");
          wr(2'd3, i, k, '0, "R12");
          rd(2'd1, i, 64'(t * 4 + f), "R2");
          rd(2'd2, i, m, "R2");
          for (int s = 0; s < 4; s++) begin
            nv = pred(v, w[s], f);
            wr(2'd0, i, w[s], fires(t, f, w[s], nv, m, k) ? N'(1) << i : '0,
               (w[s] == '0 && (f == 0 || f == 3)) ? "R11" : rq_t[t]);
            v = nv;
            rd(2'd0, i, v, rq_f[f]);
          end
          wr(2'd1, i, 64'h0, '0, "R12");
          wr(2'd0, i, 64'h5, N'(1) << i, "R10");
          @(negedge clk);
          chk(irq_o === '0, "R10", DW'(irq_o), '0);
        end
      end
    end

    // R13: same-cycle read and write
    wr(2'd1, 3, 64'h0, '0, "R12");
    wr(2'd0, 3, 64'hAAAA, N'(1) << 3, "R6");
    @(negedge clk);
    wr_i = 1'b1; rd_i = 1'b1; addr_i = {2'd0, 3'd3}; wdata_i = 64'h5555;
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0;
    chk(rdata_o === 64'hAAAA, "R13", rdata_o, 64'hAAAA);
    rd(2'd0, 3, 64'h5555, "R13");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule